// File: doc/BRIEF.md
# Byte-Loaded Stepped Register Datapath

This block is a 32-bit register datapath that is driven entirely from a narrow manual front panel. The only data path in is eight bits wide. An operator builds a 32-bit word one byte at a time, steering each byte into either an instruction holding register or a data holding register. The instruction holding register then drives the rest of the datapath combinationally. Two fields address a 32-entry register file with two read ports. A third field, or the second read field, names the write destination. The opcode field selects one of six arithmetic or logic operations.

The datapath advances only when a step strobe is given. On a step the register file may accept a write, from the data holding register or from the operation result, and the program counter moves on. It moves by one instruction length, or it takes a relative branch when a compare-and-branch instruction finds its two operands equal. A four-way selector puts the instruction word, the data word, the operation result or the program counter on a 32-bit display output. The output is meant to feed an external hexadecimal display decoder.

Top module: `switch_step_datapath`

## Requirements
- R1: A load strobe writes the 8-bit input into the byte lane named by the 2-bit lane select (0 = bits 7:0, 1 = bits 15:8, 2 = bits 23:16, 3 = bits 31:24) on the rising clock edge. The other three bytes keep their values.
- R2: The target select steers a load into the instruction holding register when 1 and into the data holding register when 0. The register not chosen is unchanged.
- R3: An active-low reset clears the program counter, both holding registers and all 32 register-file entries to zero.
- R4: The register file is written only on a clock edge where both the step strobe and the write enable are 1. The read addresses are instruction bits 25:21 (port A) and 20:16 (port B), and reads are combinational. The destination is bits 15:11 when the format select is 0 (R format) and bits 20:16 when it is 1 (I format).
- R5: The write data is the data holding register when the write-source select is 0 and the operation result when it is 1.
- R6: The opcode is instruction bits 31:26. Code 0 adds, 1 subtracts (A minus B), 2 ANDs, 3 ORs, 4 inverts operand A, 5 XORs. Every other code gives zero.
- R7: Operand B is read port B when the operand select is 0. When it is 1, operand B is instruction bits 15:0 sign-extended from bit 15.
- R8: The program counter changes only on a step. A step in I format with opcode 1 and equal operands A and B adds 4 plus the sign-extended immediate. Every other step adds 4.
- R9: The display select puts out the instruction holding register (0), the data holding register (1), the operation result (2) or the program counter (3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| byte_i | input | 8 | Byte to be loaded |
| lane_sel_i | input | 2 | Byte lane written by a load |
| load_i | input | 1 | Load strobe for the holding registers |
| load_instr_i | input | 1 | 1 loads the instruction register, 0 loads the data register |
| wr_src_alu_i | input | 1 | Write data source: 0 data register, 1 operation result |
| opnd_imm_i | input | 1 | Operand B source: 0 read port B, 1 sign-extended immediate |
| fmt_imm_i | input | 1 | Instruction format: 0 R format, 1 I format |
| wr_en_i | input | 1 | Register-file write enable, applied on a step |
| step_i | input | 1 | Step strobe: advances the program counter and commits a write |
| disp_sel_i | input | 2 | Display source select |
| disp_o | output | 32 | Selected 32-bit value for display |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 8-bit lanes, 32 register entries and a program-counter step of 4. At this size the sweeps can be complete. All four lanes are loaded in mixed orders, all 32 entries are written and read back through the operation result, and all 64 opcode codes are tried on two operand pairs, one of which is the 5-and-3 vector. The branch checks cover forward and backward offsets, unequal operands, the R-format case, and an equal compare against the immediate, while the bench keeps its own program counter model.

// File: rtl/ssd_pkg.sv
`timescale 1ns/1ps
package ssd_pkg;

  // Instruction field layout (fixed 32-bit instruction)
  localparam int OPC_W   = 6;
  localparam int OPC_LSB = 26;
  localparam int RA_LSB  = 21;
  localparam int RB_LSB  = 16;
  localparam int RD_LSB  = 11;
  localparam int IMM_W   = 16;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD = 6'd0,
    OP_SUB = 6'd1,
    OP_AND = 6'd2,
    OP_OR  = 6'd3,
    OP_NOT = 6'd4,
    OP_XOR = 6'd5
  } alu_op_e;

  typedef enum logic [1:0] {
    DISP_INSTR = 2'd0,
    DISP_DATA  = 2'd1,
    DISP_ALU   = 2'd2,
    DISP_PC    = 2'd3
  } disp_sel_e;

endpackage

// File: rtl/ssd_byte_loader.sv
`timescale 1ns/1ps
module ssd_byte_loader #(
  parameter  int WORD_W = 32,
  parameter  int BYTE_W = 8,
  localparam int LANES  = WORD_W / BYTE_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [WORD_W-1:0] word_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic              hit;
    logic [BYTE_W-1:0] lane_q;

    always_comb begin
      hit = load_i && (lane_i == LANE_W'(l));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lane_q <= '0;
      end else if (hit) begin
        lane_q <= byte_i;
      end
    end

    assign word_o[l*BYTE_W +: BYTE_W] = lane_q;
  end

endmodule

// File: rtl/ssd_regfile.sv
`timescale 1ns/1ps
module ssd_regfile #(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);

  logic [DATA_W-1:0] entry [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic              hit;
    logic [DATA_W-1:0] val_q;

    always_comb begin
      hit = we_i && (waddr_i == ADDR_W'(e));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= '0;
      end else if (hit) begin
        val_q <= wdata_i;
      end
    end

    assign entry[e] = val_q;
  end

  always_comb begin
    rdata_a_o = entry[raddr_a_i];
    rdata_b_o = entry[raddr_b_i];
  end

endmodule

// File: rtl/ssd_alu.sv
`timescale 1ns/1ps
module ssd_alu
  import ssd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OPC_W-1:0]  op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);

  always_comb begin
    case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_NOT:  res_o = ~a_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/ssd_pc_unit.sv
`timescale 1ns/1ps
module ssd_pc_unit #(
  parameter int DATA_W  = 32,
  parameter int PC_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              branch_i,
  input  logic [DATA_W-1:0] opnd_a_i,
  input  logic [DATA_W-1:0] opnd_b_i,
  input  logic [DATA_W-1:0] offset_i,
  output logic [DATA_W-1:0] pc_o
);

  logic              taken;
  logic [DATA_W-1:0] seq_pc;
  logic [DATA_W-1:0] pc_d;
  logic [DATA_W-1:0] pc_q;

  always_comb begin
    taken  = branch_i && (opnd_a_i == opnd_b_i);
    seq_pc = pc_q + DATA_W'(PC_STEP);
    pc_d   = taken ? (seq_pc + offset_i) : seq_pc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (step_i) begin
      pc_q <= pc_d;
    end
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/switch_step_datapath.sv
`timescale 1ns/1ps
module switch_step_datapath
  import ssd_pkg::*;
#(
  parameter  int DATA_W   = 32,
  parameter  int BYTE_W   = 8,
  parameter  int NUM_REGS = 32,
  parameter  int PC_STEP  = 4,
  localparam int LANE_W   = $clog2(DATA_W / BYTE_W),
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [LANE_W-1:0] lane_sel_i,
  input  logic              load_i,
  input  logic              load_instr_i,
  input  logic              wr_src_alu_i,
  input  logic              opnd_imm_i,
  input  logic              fmt_imm_i,
  input  logic              wr_en_i,
  input  logic              step_i,
  input  logic [1:0]        disp_sel_i,
  output logic [DATA_W-1:0] disp_o
);

  logic [DATA_W-1:0] instr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] alu_res;
  logic [DATA_W-1:0] rd_a;
  logic [DATA_W-1:0] rd_b;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] wr_data;
  logic [ADDR_W-1:0] wr_addr;
  logic [OPC_W-1:0]  opcode;
  logic              rf_we;
  logic              is_branch;

  // Holding registers, one loader each
  ssd_byte_loader #(.WORD_W(DATA_W), .BYTE_W(BYTE_W)) u_instr_ld (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i && load_instr_i),
    .lane_i (lane_sel_i),
    .byte_i (byte_i),
    .word_o (instr_q)
  );

  ssd_byte_loader #(.WORD_W(DATA_W), .BYTE_W(BYTE_W)) u_data_ld (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i && !load_instr_i),
    .lane_i (lane_sel_i),
    .byte_i (byte_i),
    .word_o (data_q)
  );

  // Instruction decode
  always_comb begin
    opcode    = instr_q[OPC_LSB +: OPC_W];
    imm_ext   = {{(DATA_W-IMM_W){instr_q[IMM_W-1]}}, instr_q[IMM_W-1:0]};
    wr_addr   = fmt_imm_i ? instr_q[RB_LSB +: ADDR_W] : instr_q[RD_LSB +: ADDR_W];
    opnd_b    = opnd_imm_i ? imm_ext : rd_b;
    wr_data   = wr_src_alu_i ? alu_res : data_q;
    rf_we     = step_i && wr_en_i;
    is_branch = fmt_imm_i && (opcode == OP_SUB);
  end

  ssd_regfile #(.DATA_W(DATA_W), .DEPTH(NUM_REGS)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (wr_addr),
    .wdata_i   (wr_data),
    .raddr_a_i (instr_q[RA_LSB +: ADDR_W]),
    .raddr_b_i (instr_q[RB_LSB +: ADDR_W]),
    .rdata_a_o (rd_a),
    .rdata_b_o (rd_b)
  );

  ssd_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (opcode),
    .a_i   (rd_a),
    .b_i   (opnd_b),
    .res_o (alu_res)
  );

  ssd_pc_unit #(.DATA_W(DATA_W), .PC_STEP(PC_STEP)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step_i),
    .branch_i (is_branch),
    .opnd_a_i (rd_a),
    .opnd_b_i (opnd_b),
    .offset_i (imm_ext),
    .pc_o     (pc_q)
  );

  // Display selector
  always_comb begin
    case (disp_sel_i)
      DISP_INSTR: disp_o = instr_q;
      DISP_DATA:  disp_o = data_q;
      DISP_ALU:   disp_o = alu_res;
      default:    disp_o = pc_q;
    endcase
  end

endmodule

// File: rtl/switch_step_datapath_chk.sv
`timescale 1ns/1ps
module switch_step_datapath_chk
  import ssd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PC_STEP = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              load_instr_i,
  input logic [1:0]        lane_sel_i,
  input logic [7:0]        byte_i,
  input logic              step_i,
  input logic              fmt_imm_i,
  input logic [1:0]        disp_sel_i,
  input logic [DATA_W-1:0] disp_o,
  input logic [DATA_W-1:0] instr_q,
  input logic [DATA_W-1:0] data_q,
  input logic [DATA_W-1:0] pc_q,
  input logic [DATA_W-1:0] alu_res
);

  // R2
  instr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !load_instr_i) |=> $stable(instr_q));

  // R2
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_instr_i) |=> $stable(data_q));

  // R1
  lane0_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !load_instr_i && lane_sel_i == 2'd0)
      |=> (data_q[7:0] == $past(byte_i)) && (data_q[DATA_W-1:8] == $past(data_q[DATA_W-1:8])));

  // R8
  pc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pc_q));

  // R8
  pc_linear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !(fmt_imm_i && instr_q[OPC_LSB +: OPC_W] == OP_SUB))
      |=> pc_q == $past(pc_q) + DATA_W'(PC_STEP));

  // R6
  alu_undef_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_q[OPC_LSB +: OPC_W] > 6'd5) |-> alu_res == '0);

  // R9
  disp_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_sel_i == 2'd3) |-> disp_o == pc_q);

endmodule

bind switch_step_datapath switch_step_datapath_chk #(
  .DATA_W  (DATA_W),
  .PC_STEP (PC_STEP)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .load_i       (load_i),
  .load_instr_i (load_instr_i),
  .lane_sel_i   (lane_sel_i),
  .byte_i       (byte_i),
  .step_i       (step_i),
  .fmt_imm_i    (fmt_imm_i),
  .disp_sel_i   (disp_sel_i),
  .disp_o       (disp_o),
  .instr_q      (instr_q),
  .data_q       (data_q),
  .pc_q         (pc_q),
  .alu_res      (alu_res)
);

// File: tb/switch_step_datapath_tb_top.sv
`timescale 1ns/1ps
module switch_step_datapath_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [7:0]  byte_i;
  logic [1:0]  lane_sel_i;
  logic        load_i;
  logic        load_instr_i;
  logic        wr_src_alu_i;
  logic        opnd_imm_i;
  logic        fmt_imm_i;
  logic        wr_en_i;
  logic        step_i;
  logic [1:0]  disp_sel_i;
  logic [31:0] disp_o;

  int          n_checks = 0;
  int          n_errors = 0;
  logic [31:0] mdl [32];
  logic [31:0] exp_pc;
  logic [31:0] exp_data;
  logic [31:0] exp_instr;

  always #2.5 clk = ~clk;

  switch_step_datapath dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .byte_i       (byte_i),
    .lane_sel_i   (lane_sel_i),
    .load_i       (load_i),
    .load_instr_i (load_instr_i),
    .wr_src_alu_i (wr_src_alu_i),
    .opnd_imm_i   (opnd_imm_i),
    .fmt_imm_i    (fmt_imm_i),
    .wr_en_i      (wr_en_i),
    .step_i       (step_i),
    .disp_sel_i   (disp_sel_i),
    .disp_o       (disp_o)
  );

  function automatic logic [31:0] r_word(input logic [5:0] op, input logic [4:0] ra,
                                         input logic [4:0] rb, input logic [4:0] rd);
    return {op, ra, rb, rd, 11'd0};
  endfunction

  function automatic logic [31:0] i_word(input logic [5:0] op, input logic [4:0] ra,
                                         input logic [4:0] rb, input logic [15:0] imm);
    return {op, ra, rb, imm};
  endfunction

  function automatic logic [31:0] alu_ref(input int op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return ~a;
      5: return a ^ b;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [1:0] sel, input logic [31:0] exp);
    disp_sel_i = sel;
    #1;
    n_checks++;
    if (disp_o !== exp) begin
      n_errors++;
      $display("FAIL %s: sel=%0d actual=%h expected=%h", tag, sel, disp_o, exp);
    end
  endtask

  task automatic load_lane(input bit to_instr, input int lane, input logic [7:0] b);
    @(negedge clk);
    load_i = 1'b1; load_instr_i = to_instr; lane_sel_i = lane[1:0]; byte_i = b;
    @(negedge clk);
    load_i = 1'b0;
    if (to_instr) exp_instr[8*lane +: 8] = b;
    else          exp_data[8*lane +: 8] = b;
  endtask

  task automatic load_word(input bit to_instr, input logic [31:0] w);
    for (int k = 0; k < 4; k++) load_lane(to_instr, k, w[8*k +: 8]);
  endtask

  task automatic do_step(input bit we, input bit src_alu, input bit fmt);
    @(negedge clk);
    step_i = 1'b1; wr_en_i = we; wr_src_alu_i = src_alu; fmt_imm_i = fmt;
    @(negedge clk);
    step_i = 1'b0; wr_en_i = 1'b0;
  endtask

  task automatic write_reg(input int idx, input logic [31:0] val);
    load_word(1'b0, val);
    load_word(1'b1, i_word(6'd0, 5'd0, idx[4:0], 16'd0));
    do_step(1'b1, 1'b0, 1'b1);
    exp_pc += 32'd4;
    mdl[idx] = val;
  endtask

  task automatic read_reg(input string tag, input int idx, input logic [31:0] exp);
    load_word(1'b1, r_word(6'd0, idx[4:0], 5'd0, 5'd0));
    opnd_imm_i = 1'b1;
    check(tag, 2'd2, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; byte_i = '0; lane_sel_i = '0; load_i = 1'b0; load_instr_i = 1'b0;
    wr_src_alu_i = 1'b0; opnd_imm_i = 1'b0; fmt_imm_i = 1'b0; wr_en_i = 1'b0;
    step_i = 1'b0; disp_sel_i = '0;
    exp_pc = '0; exp_data = '0; exp_instr = '0;
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R3: reset state on every display source and every entry
    check("R3 instr", 2'd0, 32'd0);
    check("R3 data", 2'd1, 32'd0);
    check("R3 alu", 2'd2, 32'd0);
    check("R3 pc", 2'd3, 32'd0);
    for (int i = 0; i < 32; i++) read_reg("R3 entry", i, 32'd0);

    // R1: single lanes in mixed order, other bytes hold
    load_lane(1'b0, 2, 8'hAB);
    check("R1 lane2", 2'd1, 32'h00AB0000);
    load_lane(1'b0, 0, 8'h11);
    check("R1 lane0", 2'd1, 32'h00AB0011);
    load_lane(1'b0, 3, 8'hC4);
    load_lane(1'b0, 1, 8'h5E);
    check("R1 all lanes", 2'd1, 32'hC4AB5E11);
    // R2: the instruction register ignored those data loads
    check("R2 instr kept", 2'd0, exp_instr);
    load_lane(1'b1, 1, 8'h77);
    check("R2 data kept", 2'd1, 32'hC4AB5E11);
    check("R2 instr loaded", 2'd0, exp_instr);

    // R4 R5: fill all 32 entries from the data register (I-format destination)
    for (int i = 0; i < 32; i++) write_reg(i, (32'(i + 1) * 32'h9E3779B9) ^ 32'(i));
    for (int i = 0; i < 32; i++) read_reg("R4 write/read", i, mdl[i]);
    check("R8 linear steps", 2'd3, exp_pc);

    // R4: step without write enable leaves the entry alone
    load_word(1'b0, 32'hDEADBEEF);
    load_word(1'b1, i_word(6'd0, 5'd0, 5'd5, 16'd0));
    do_step(1'b0, 1'b0, 1'b1);
    exp_pc += 32'd4;
    read_reg("R4 no write", 5, mdl[5]);
    // R4: R-format destination from bits 15:11
    load_word(1'b0, 32'h0BADF00D);
    load_word(1'b1, r_word(6'd0, 5'd0, 5'd6, 5'd7));
    do_step(1'b1, 1'b0, 1'b0);
    exp_pc += 32'd4;
    mdl[7] = 32'h0BADF00D;
    read_reg("R4 rformat dest", 7, mdl[7]);
    read_reg("R4 rformat rb untouched", 6, mdl[6]);

    // R6: all 64 opcodes on the 5/3 vector and on a second pair
    write_reg(1, 32'd5);
    write_reg(2, 32'd3);
    opnd_imm_i = 1'b0;
    for (int op = 0; op < 64; op++) begin
      load_word(1'b1, r_word(6'(op), 5'd1, 5'd2, 5'd0));
      opnd_imm_i = 1'b0;
      check("R6 op sweep 5/3", 2'd2, alu_ref(op, 32'd5, 32'd3));
    end
    for (int op = 0; op < 64; op++) begin
      load_word(1'b1, r_word(6'(op), 5'd11, 5'd12, 5'd0));
      opnd_imm_i = 1'b0;
      check("R6 op sweep pair2", 2'd2, alu_ref(op, mdl[11], mdl[12]));
    end

    // R7: operand B from sign-extended immediate or from port B
    load_word(1'b1, i_word(6'd0, 5'd1, 5'd2, 16'h8003));
    opnd_imm_i = 1'b1;
    check("R7 negative imm", 2'd2, 32'hFFFF8008);
    opnd_imm_i = 1'b0;
    check("R7 port B", 2'd2, 32'd8);
    load_word(1'b1, i_word(6'd3, 5'd2, 5'd0, 16'h00F0));
    opnd_imm_i = 1'b1;
    check("R7 positive imm", 2'd2, 32'h000000F3);

    // R5: write the operation result, R and I formats
    load_word(1'b1, r_word(6'd0, 5'd1, 5'd2, 5'd10));
    opnd_imm_i = 1'b0;
    do_step(1'b1, 1'b1, 1'b0);
    exp_pc += 32'd4;
    mdl[10] = 32'd8;
    read_reg("R5 alu write r", 10, 32'd8);
    load_word(1'b1, i_word(6'd5, 5'd1, 5'd20, 16'h00FF));
    opnd_imm_i = 1'b1;
    do_step(1'b1, 1'b1, 1'b1);
    exp_pc += 32'd4;
    mdl[20] = 32'h000000FA;
    read_reg("R5 alu write i", 20, 32'h000000FA);

    // R8: branch cases
    write_reg(3, 32'd5);
    check("R8 pc before branch", 2'd3, exp_pc);
    load_word(1'b1, i_word(6'd1, 5'd1, 5'd3, 16'h0010));
    opnd_imm_i = 1'b0;
    do_step(1'b0, 1'b0, 1'b1);
    exp_pc += 32'd20;
    check("R8 taken forward", 2'd3, exp_pc);
    load_word(1'b1, i_word(6'd1, 5'd1, 5'd3, 16'hFFF8));
    do_step(1'b0, 1'b0, 1'b1);
    exp_pc = exp_pc + 32'd4 - 32'd8;
    check("R8 taken backward", 2'd3, exp_pc);
    load_word(1'b1, i_word(6'd1, 5'd1, 5'd2, 16'h0010));
    do_step(1'b0, 1'b0, 1'b1);
    exp_pc += 32'd4;
    check("R8 not equal", 2'd3, exp_pc);
    load_word(1'b1, i_word(6'd1, 5'd1, 5'd3, 16'h0010));
    do_step(1'b0, 1'b0, 1'b0);
    exp_pc += 32'd4;
    check("R8 r format no branch", 2'd3, exp_pc);
    load_word(1'b1, i_word(6'd1, 5'd1, 5'd0, 16'h0005));
    opnd_imm_i = 1'b1;
    do_step(1'b0, 1'b0, 1'b1);
    exp_pc += 32'd9;
    check("R8 equal to imm", 2'd3, exp_pc);
    repeat (3) @(negedge clk);
    check("R8 hold without step", 2'd3, exp_pc);

    // R9: every display source
    check("R9 instr", 2'd0, i_word(6'd1, 5'd1, 5'd0, 16'h0005));
    check("R9 data", 2'd1, exp_data);
    check("R9 alu", 2'd2, 32'd0);
    check("R9 pc", 2'd3, exp_pc);

    // R3: reset in mid-run clears state again
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R3 midrun pc", 2'd3, 32'd0);
    check("R3 midrun data", 2'd1, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    exp_instr = '0; exp_data = '0;
    read_reg("R3 midrun entry1", 1, 32'd0);
    read_reg("R3 midrun entry31", 31, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule